// File: doc/BRIEF.md
# Strobed Bidirectional Port with Interrupts

This block is an eight-bit general-purpose parallel port with a handshake strobe pin, controlled through a small register window of four addresses. In input mode, an external strobe works like the enable of a transparent latch. The data register follows the pins while the strobe is at its active level, and it keeps the last value once the strobe returns to idle. That trailing edge also sets two interrupt flags: one for this port and one shared. An interrupt request leaves the block when the port flag is set and interrupts are enabled.

In output mode, a write to the data register drives the value onto the pins at once and holds it until the next write. The same write sends a single strobe pulse of a fixed number of clock cycles. One configuration bit sets the active level of the strobe in both directions. A second bit chooses between push-pull drive and open-drain drive, where open-drain only pulls low. The input strobe passes through a two-flop synchroniser before its edges are detected.

Top module: `strobe_port`

## Requirements
- R1: After reset the data register and both flags read 0, and the configuration is 0: input mode, active-low strobe, push-pull, interrupts disabled. `irq`, `stb_oe` and every `pin_oe` bit are 0, and `stb_out` rests at its idle level of 1.
- R2: In input mode, while the synchronised strobe is active, the data register (address 0) follows the pins. After the trailing edge it holds the last value seen, and later pin changes do not affect it.
- R3: Address 1 returns the live pin levels `pin_in` in both input and output mode.
- R4: Configuration bit 1 (address 2) sets the strobe polarity: 1 means active high and 0 means active low. It applies to the input strobe and to the generated output strobe.
- R5: In input mode, the trailing edge of a strobe sets bit 0 (port flag) and bit 1 (shared flag) of the flag register at address 3.
- R6: Writing a 1 to a flag bit at address 3 clears that bit. A 0 leaves it unchanged.
- R7: `irq` is high exactly when configuration bit 3 (enable) and the port flag are both 1.
- R8: In output mode (configuration bit 0 = 1), a data write shows on the pins in the cycle after the write edge. The value stays until the next write.
- R9: Each output-mode data write produces one strobe pulse at the active level lasting exactly PULSE_CYCLES clock cycles. At other times `stb_out` rests at the inactive level. `stb_oe` is 1 only in output mode.
- R10: With configuration bit 2 = 0, output mode drives every pin with `pin_out` equal to the data. With bit 2 = 1 (open-drain), `pin_out` is 0 and `pin_oe` is the inverse of the data, so that only low bits are driven.
- R11: In input mode, writes to the data register are ignored. In output mode, activity on `stb_in` sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 data, 1 pins, 2 configuration, 3 flags |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data of the selected register |
| pin_in | input | WIDTH | Resolved pad levels |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Pad output enables, one per bit |
| stb_in | input | 1 | Strobe from the external device |
| stb_out | output | 1 | Generated strobe |
| stb_oe | output | 1 | Strobe pad drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the port with WIDTH = 8 and PULSE_CYCLES = 3. The short pulse lets the monitor measure the whole strobe width of every output write, cycle by cycle, at both polarities. An eight-bit width allows asymmetric patterns such as A5, C3 and 96, so an inverted, shifted or partially driven bit shows in both the push-pull pin values and the open-drain enable masks.

// File: rtl/strobe_port.sv
module strobe_port #(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic             stb_in,
  output logic             stb_out,
  output logic             stb_oe,
  output logic             irq
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [WIDTH-1:0] data_q;
  logic             dir_q, pol_q, od_q, en_q;
  logic             flag_port_q, flag_all_q;
  logic [2:0]       sync_q;
  logic [CW-1:0]    cnt_q;

  wire wr_data = reg_wr && reg_addr == 2'd0;
  wire wr_cfg  = reg_wr && reg_addr == 2'd2;
  wire wr_flag = reg_wr && reg_addr == 2'd3;
  wire act_now  = (sync_q[1] == pol_q);
  wire act_prev = (sync_q[2] == pol_q);
  wire trail    = !dir_q && act_prev && !act_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 3'b111;
      data_q      <= '0;
      {en_q, od_q, pol_q, dir_q} <= 4'b0;
      flag_port_q <= 1'b0;
      flag_all_q  <= 1'b0;
      cnt_q       <= '0;
    end else begin
      sync_q <= {sync_q[1:0], stb_in};
      if (dir_q && wr_data)      data_q <= reg_wdata;
      else if (!dir_q && act_now) data_q <= pin_in;
      if (wr_cfg) {en_q, od_q, pol_q, dir_q} <= reg_wdata[3:0];
      flag_port_q <= trail | (flag_port_q & ~(wr_flag & reg_wdata[0]));
      flag_all_q  <= trail | (flag_all_q  & ~(wr_flag & reg_wdata[1]));
      if (dir_q && wr_data)  cnt_q <= CW'(PULSE_CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = data_q;
      2'd1:    reg_rdata = pin_in;
      2'd2:    reg_rdata = {{(WIDTH-4){1'b0}}, en_q, od_q, pol_q, dir_q};
      default: reg_rdata = {{(WIDTH-2){1'b0}}, flag_all_q, flag_port_q};
    endcase
  end

  assign pin_out = (dir_q && !od_q) ? data_q : '0;
  assign pin_oe  = !dir_q ? '0 : (od_q ? ~data_q : '1);
  assign stb_out = (cnt_q != '0) ? pol_q : ~pol_q;
  assign stb_oe  = dir_q;
  assign irq     = en_q & flag_port_q;

  // R5
  trail_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q && act_prev && !act_now) |=> (flag_port_q && flag_all_q));
  // R9
  pulse_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q && wr_data) |=> (cnt_q == CW'(PULSE_CYCLES)));
  // R9
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !(dir_q && wr_data)) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R11
  input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q && !act_now && !wr_cfg) |=> $stable(data_q));
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && reg_wdata[0] && !trail) |=> !flag_port_q);
endmodule

// File: tb/strobe_port_bench.sv
`timescale 1ns/1ps
module strobe_port_bench;
  localparam int W = 8;
  localparam int P = 3;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata;
  logic [W-1:0] pin_out, pin_oe, ext = 8'hFF;
  wire  [W-1:0] pin_in = (pin_out & pin_oe) | (ext & ~pin_oe);
  logic stb_in = 1, stb_out, stb_oe, irq;

  int errors = 0, checks = 0;
  bit done = 0;
  logic pol_exp = 0;
  logic [W-1:0] exp_q[$];
  int run = 0;

  strobe_port #(.WIDTH(W), .PULSE_CYCLES(P)) u_strobe_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .stb_in(stb_in), .stb_out(stb_out),
    .stb_oe(stb_oe), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic drive_out(input logic [W-1:0] d);
    exp_q.push_back(d);
    wr(2'd0, d);
  endtask

  task automatic strobe_pulse(input logic [W-1:0] d, input logic pol);
    @(negedge clk); ext = d; stb_in = pol;
    repeat (3) @(negedge clk);
    stb_in = ~pol;
    repeat (3) @(negedge clk);
    ext = ~d;
    repeat (3) @(negedge clk);
  endtask

  // monitor: measures each output strobe and compares with queued expectations
  always @(negedge clk) begin
    if (rst_n && stb_oe && stb_out == pol_exp) run++;
    else if (run > 0) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected pulse", run, 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(pin_in == e, "R8 pins at pulse end", pin_in, e);
        check(run == P, "R9 pulse width", run, P);
      end
      run = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk(2'd0, 8'h00, "R1 data");
    rd_chk(2'd2, 8'h00, "R1 config");
    rd_chk(2'd3, 8'h00, "R1 flags");
    check(irq == 0 && stb_oe == 0 && pin_oe == 0 && stb_out == 1, "R1 outputs",
          {irq, stb_oe, stb_out}, 3'b001);

    // R2 R5 R7: active-low input strobe with interrupt enabled
    wr(2'd2, 8'h08);
    strobe_pulse(8'hA5, 1'b0);
    rd_chk(2'd0, 8'hA5, "R2 captured");
    rd_chk(2'd3, 8'h03, "R5 flags set");
    check(irq == 1, "R7 irq on", irq, 1);
    rd_chk(2'd1, 8'h5A, "R3 live pins input");

    // R6 write-one-to-clear
    wr(2'd3, 8'h02);
    rd_chk(2'd3, 8'h01, "R6 clear shared only");
    wr(2'd3, 8'h00);
    rd_chk(2'd3, 8'h01, "R6 zero write");
    check(irq == 1, "R7 irq held", irq, 1);
    wr(2'd3, 8'h01);
    rd_chk(2'd3, 8'h00, "R6 clear port");
    check(irq == 0, "R7 irq off", irq, 0);

    // R7 flag without enable
    wr(2'd2, 8'h00);
    strobe_pulse(8'h3C, 1'b0);
    rd_chk(2'd3, 8'h03, "R5 flags no enable");
    check(irq == 0, "R7 masked", irq, 0);
    wr(2'd3, 8'h03);

    // R11 output mode strobe_in ignored; R8 R9 R10 push-pull, active-high
    wr(2'd2, 8'h03); pol_exp = 1;
    check(stb_oe == 1 && stb_out == 0, "R9 idle high-pol", stb_out, 0);
    @(negedge clk); stb_in = 0;
    repeat (3) @(negedge clk); stb_in = 1;
    repeat (3) @(negedge clk); stb_in = 0;
    repeat (4) @(negedge clk);
    rd_chk(2'd3, 8'h00, "R11 no flag in output");
    drive_out(8'h5A);
    @(negedge clk);
    check(pin_out == 8'h5A && pin_oe == 8'hFF, "R10 push-pull", pin_out, 8'h5A);
    rd_chk(2'd1, 8'h5A, "R3 live pins output");
    repeat (6) @(negedge clk);

    // R10 open-drain
    ext = 8'hFF;
    wr(2'd2, 8'h07);
    drive_out(8'hC3);
    @(negedge clk);
    check(pin_oe == 8'h3C && pin_out == 8'h00, "R10 open-drain", pin_oe, 8'h3C);
    repeat (6) @(negedge clk);

    // R4 active-low output strobe, R8 hold
    wr(2'd2, 8'h01); pol_exp = 0;
    drive_out(8'h81);
    repeat (10) @(negedge clk);
    check(pin_out == 8'h81, "R8 held", pin_out, 8'h81);
    check(stb_out == 1, "R4 low-pol idle", stb_out, 1);

    // R4 active-high input strobe
    wr(2'd2, 8'h0A);
    strobe_pulse(8'h96, 1'b1);
    rd_chk(2'd0, 8'h96, "R4 high-pol capture");
    rd_chk(2'd3, 8'h03, "R4 high-pol flags");
    // R11 data write ignored in input mode
    wr(2'd0, 8'h11);
    rd_chk(2'd0, 8'h96, "R11 input write ignored");

    check(exp_q.size() == 0, "R9 all pulses seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule